// File: doc/BRIEF.md
# Extended-Precision Fractional Multiplier

This block multiplies two signed fractional numbers in Q1.63 form, each held in 64 bits, and returns a Q1.63 product. It contains one 33x33 signed multiplier, so each operand is split into a signed upper 32-bit half and an unsigned lower 32-bit half. The partial products are formed one per cycle and summed in a wide accumulator. The 128-bit product is then reduced to 64 bits by dropping its low bits. Because the product carries a redundant sign bit, it is taken from bit 63 upward.

A caller presents both operands and a mode bit, then pulses `start`. In exact mode the low-by-low partial product is included. Its upper half seeds the accumulator, and the result is the exact product truncated toward minus infinity. In fast mode that partial product is skipped, which saves one cycle. The result can then fall a least significant bit or two below the exact value. When the result is ready, `done` pulses for one cycle, and `result` holds its value until the next computation finishes.

Top module: `xpm_frac_mul`

## Requirements
- R1: While reset is applied and after it is released, `result` is 0 and `done` is 0 until the first computation completes.
- R2: With `mode_full`=1, `result` equals floor(A*B / 2^63) modulo 2^64, where A and B are the two's-complement integers in `op_a` and `op_b`.
- R3: With `mode_full`=0, `result` equals floor((A*B - La*Lb) / 2^63) modulo 2^64, where La and Lb are the unsigned values of bits 31:0 of `op_a` and `op_b`.
- R4: The product of 0x8000_0000_0000_0000 with itself (-1.0 by -1.0) wraps to 0x8000_0000_0000_0000 in both modes.
- R5: `done` is high for exactly one cycle. It rises 6 clock edges after the edge that sampled `start` in exact mode, and 5 edges after it in fast mode.
- R6: `result` does not change between two completions. It keeps its value after `done` falls.
- R7: A `start` that arrives while a computation is in progress is ignored. It changes neither the result nor the timing of the computation in progress.
- R8: Operands and mode are captured on the edge that samples `start`. Later changes on `op_a`, `op_b` or `mode_full` have no effect on that computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation when idle |
| mode_full | input | 1 | 1 = exact (64-bit) product, 0 = fast variant without the low-by-low term |
| op_a | input | 64 | Multiplicand, signed Q1.63 |
| op_b | input | 64 | Multiplier, signed Q1.63 |
| result | output | 64 | Truncated Q1.63 product, held between completions |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
Each computation is due 6 clock edges after its `start` edge in exact mode and 5 edges after it in fast mode. The bench stamps each scheduled item with the cycle number of the edge that samples `start`. The monitor pops an item only when `done` is seen, then compares both the value and the elapsed edge count against the mode's latency. After each completion, the bench samples `result` for several further cycles to confirm it holds. During a computation the bench scrambles the operand inputs and injects a stray `start`. It then confirms that the result still matches the operands captured at the original `start` edge.

// File: rtl/xpm_pkg.sv
package xpm_pkg;
  localparam int unsigned HALF_W = 32;
  localparam int unsigned WORD_W = 2 * HALF_W;
  localparam int unsigned PROD_W = 2 * HALF_W + 2;
  localparam int unsigned ACC_W  = 80;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LL    = 3'd1,
    ST_HL    = 3'd2,
    ST_LH    = 3'd3,
    ST_HH    = 3'd4,
    ST_ADDLO = 3'd5,
    ST_ADDHI = 3'd6
  } xpm_state_e;

  // Extend one 32-bit half to 33 bits, signed (upper half) or unsigned (lower half).
  function automatic logic [HALF_W:0] ext_half(input logic [HALF_W-1:0] h, input logic is_signed);
    return {is_signed & h[HALF_W-1], h};
  endfunction

  // Signed product of two 33-bit extended halves.
  function automatic logic signed [PROD_W-1:0] mul_half(input logic [HALF_W:0] x, input logic [HALF_W:0] y);
    logic signed [PROD_W-1:0] xw, yw;
    xw = $signed({{(PROD_W-HALF_W-1){x[HALF_W]}}, x});
    yw = $signed({{(PROD_W-HALF_W-1){y[HALF_W]}}, y});
    return xw * yw;
  endfunction

  // Bring the accumulated cross sum into the weight of the doubled high product.
  function automatic logic [WORD_W-1:0] align_cross(input logic [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] s;
    s = $signed(acc) >>> (HALF_W - 1);
    return s[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/xpm_ctrl.sv
module xpm_ctrl
  import xpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mode_full,
  output xpm_state_e state,
  output logic       op_load,
  output logic       done
);
  xpm_state_e state_q, state_d;
  logic       done_q;

  assign op_load = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = mode_full ? ST_LL : ST_HL;
      ST_LL:    state_d = ST_HL;
      ST_HL:    state_d = ST_LH;
      ST_LH:    state_d = ST_HH;
      ST_HH:    state_d = ST_ADDLO;
      ST_ADDLO: state_d = ST_ADDHI;
      ST_ADDHI: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_ADDHI);
    end
  end

  assign state = state_q;
  assign done  = done_q;

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R5
  done_after_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDHI) |=> done);
  // R7
  busy_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start) |=> (state_q != ST_LL));
endmodule

// File: rtl/xpm_pmul.sv
module xpm_pmul
  import xpm_pkg::*;
(
  input  logic [WORD_W-1:0]        a,
  input  logic [WORD_W-1:0]        b,
  input  xpm_state_e               state,
  output logic signed [PROD_W-1:0] prod
);
  logic             a_hi, b_hi;
  logic [HALF_W:0]  a_ext, b_ext;

  assign a_hi = (state == ST_HL) || (state == ST_HH);
  assign b_hi = (state == ST_LH) || (state == ST_HH);

  assign a_ext = ext_half(a_hi ? a[WORD_W-1:HALF_W] : a[HALF_W-1:0], a_hi);
  assign b_ext = ext_half(b_hi ? b[WORD_W-1:HALF_W] : b[HALF_W-1:0], b_hi);

  assign prod = mul_half(a_ext, b_ext);

  // R2: the low-by-low product is unsigned and never negative
  always_comb begin
    if (state == ST_LL) ll_sign_chk: assert (!prod[PROD_W-1]);
  end
endmodule

// File: rtl/xpm_acc.sv
module xpm_acc
  import xpm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  xpm_state_e               state,
  input  logic signed [PROD_W-1:0] prod,
  output logic [WORD_W-1:0]        result
);
  localparam int unsigned GUARD_LO = PROD_W + 1;

  logic [ACC_W-1:0]  acc_q;
  logic [WORD_W-1:0] hh_q, res_q, hh_dbl, al;
  logic [HALF_W-1:0] lo_q;
  logic              cy_q;
  logic [HALF_W:0]   lo_sum;
  logic [HALF_W-1:0] hi_sum;

  assign hh_dbl = {hh_q[WORD_W-2:0], 1'b0};
  assign al     = align_cross(acc_q);
  assign lo_sum = {1'b0, hh_dbl[HALF_W-1:0]} + {1'b0, al[HALF_W-1:0]};
  assign hi_sum = hh_dbl[WORD_W-1:HALF_W] + al[WORD_W-1:HALF_W] + {{(HALF_W-1){1'b0}}, cy_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      hh_q  <= '0;
      lo_q  <= '0;
      cy_q  <= 1'b0;
      res_q <= '0;
    end else if (clear) begin
      acc_q <= '0;
    end else begin
      unique case (state)
        ST_LL:    acc_q <= {{(ACC_W-HALF_W){1'b0}}, prod[WORD_W-1:HALF_W]};
        ST_HL,
        ST_LH:    acc_q <= acc_q + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        ST_HH:    hh_q  <= prod[WORD_W-1:0];
        ST_ADDLO: {cy_q, lo_q} <= lo_sum;
        ST_ADDHI: res_q <= {hi_sum, lo_q};
        default:  ;
      endcase
    end
  end

  assign result = res_q;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q[ACC_W-1:GUARD_LO] == {(ACC_W-GUARD_LO){acc_q[GUARD_LO-1]}});
endmodule

// File: rtl/xpm_frac_mul.sv
module xpm_frac_mul
  import xpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        mode_full,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  output logic [63:0] result,
  output logic        done
);
  xpm_state_e               state;
  logic                     op_load;
  logic [WORD_W-1:0]        opa_q, opb_q;
  logic                     mode_q;
  logic signed [PROD_W-1:0] prod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q  <= '0;
      opb_q  <= '0;
      mode_q <= 1'b0;
    end else if (op_load) begin
      opa_q  <= op_a;
      opb_q  <= op_b;
      mode_q <= mode_full;
    end
  end

  xpm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_full(mode_full),
    .state(state), .op_load(op_load), .done(done)
  );

  xpm_pmul u_pmul (.a(opa_q), .b(opb_q), .state(state), .prod(prod));

  xpm_acc u_acc (
    .clk(clk), .rst_n(rst_n), .clear(op_load), .state(state),
    .prod(prod), .result(result)
  );

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result));
  // R8
  ops_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($stable(opa_q) && $stable(opb_q) && $stable(mode_q)));
  // R3: fast mode never visits the low-by-low step
  fast_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && !mode_full) |=> (state == ST_HL));
endmodule

// File: tb/xpm_frac_mul_bench.sv
module xpm_frac_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode_full = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [63:0] result;
  logic        done;

  typedef struct {
    logic [63:0] exp;
    int          lat;
    int          icyc;
    logic        full;
  } item_t;

  item_t       sb[$];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  int          hold_cnt = 0;
  logic [63:0] held = '0;
  logic        done_prev = 1'b0;
  bit          finished = 0;

  always #4 clk = ~clk;

  xpm_frac_mul u_xpm_frac_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_full(mode_full),
    .op_a(op_a), .op_b(op_b), .result(result), .done(done)
  );

  function automatic logic [63:0] exp_full(input logic [63:0] a, input logic [63:0] b);
    logic signed [127:0] p;
    p = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
    p = p >>> 63;
    return p[63:0];
  endfunction

  function automatic logic [63:0] exp_fast(input logic [63:0] a, input logic [63:0] b);
    logic signed [127:0] p, ll;
    p  = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
    ll = $signed({96'b0, a[31:0]} * {96'b0, b[31:0]});
    p  = (p - ll) >>> 63;
    return p[63:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_cnt > 0) begin
        check(result == held, "R6 hold", result, held);
        hold_cnt--;
      end
      if (done && done_prev)
        check(1'b0, "R5 pulse width", 64'd1, 64'd0);
      if (done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R7 unexpected done", 64'd1, 64'd0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(result == it.exp, it.full ? "R2 exact value" : "R3 fast value", result, it.exp);
          check((cyc - it.icyc) == it.lat, "R5 latency", 64'(cyc - it.icyc), 64'(it.lat));
          held = it.exp;
          hold_cnt = 3;
        end
      end
      done_prev <= done;
    end
  end

  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic m, input bit intrude);
    item_t it;
    @(negedge clk);
    op_a = a; op_b = b; mode_full = m; start = 1'b1;
    it.exp  = m ? exp_full(a, b) : exp_fast(a, b);
    it.lat  = m ? 6 : 5;
    it.icyc = cyc + 1;
    it.full = m;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    op_a = ~a; op_b = b ^ 64'h5A5A_0F0F_A5A5_F0F0; mode_full = ~m; // R8 scramble
    if (intrude) begin                                            // R7 stray start
      @(negedge clk);
      start = 1'b1; op_a = {$urandom, $urandom}; op_b = {$urandom, $urandom};
      @(negedge clk);
      start = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(result == 64'd0 && done == 1'b0, "R1 in reset", result, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(result == 64'd0 && done == 1'b0, "R1 after reset", result, 64'd0);

    // R2: 0.5 * 0.5
    issue(64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b1, 0);
    // R3: same in fast mode
    issue(64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0, 0);
    // R4: -1 * -1 wraps, both modes
    issue(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 0);
    check(result == 64'h8000_0000_0000_0000, "R4 wrap exact", result, 64'h8000_0000_0000_0000);
    issue(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 0);
    check(result == 64'h8000_0000_0000_0000, "R4 wrap fast", result, 64'h8000_0000_0000_0000);
    // R2/R3: low halves dominate, where the modes differ
    issue(64'h0000_0000_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 0);
    issue(64'h0000_0000_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 0);
    issue(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 0);
    issue(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 0);
    // R7/R8: stray start while busy, scrambled inputs
    issue(64'h3C3C_1234_8765_4321, 64'hC001_D00D_FEED_BEEF, 1'b1, 1);
    issue(64'h9ABC_DEF0_1234_5678, 64'h5555_5555_AAAA_AAAA, 1'b0, 1);
    for (int i = 0; i < 40; i++)
      issue({$urandom, $urandom}, {$urandom, $urandom}, i[0], i % 5 == 0);
    summary();
  end
endmodule